// File: doc/BRIEF.md
# Serial Divider-Ratio Loader

This block takes a three-wire serial stream (a bit clock, a data line and a latch strobe) and turns it into two 16-bit divider ratios for a frequency synthesizer: one for the reference path and one for the feedback path. A 17-bit word is shifted in with the most significant ratio bit first. The last bit shifted in is a control bit that says which of the two holding latches the ratio is meant for. Pulsing the latch strobe high copies the ratio field into that latch and leaves the other latch untouched.

Each latch also drives a registered disable flag. The flag is high whenever the latch holds zero. Downstream logic uses these flags to stop the oscillator and reference divider, or to stop the feedback counter and float the charge-pump outputs. Reset clears both latches, so the synthesizer starts in standby.

All three serial inputs are treated as signals that are already synchronous to the system clock `clk`. A rising edge of the bit clock is found by comparing it with its value on the previous cycle.

Top module: `serial_ratio_loader`

## Requirements
- R1: During and after reset, before any transfer, `refRatio` and `fbRatio` read 0 and `refDisable` and `fbDisable` read 1.
- R2: A data bit is taken in only on a cycle where `serClk` is high and was low on the previous `clk` cycle. That bit is the value of `serData` on that same cycle. Holding `serClk` high, or changing `serData` while it is high, takes in nothing further.
- R3: The shift register keeps the last 17 bits taken in. The earliest of those 17 bits is ratio bit 15 (MSB), the 16th is ratio bit 0 (LSB), and the 17th is the control bit.
- R4: On a cycle where `serLatch` is high and the control bit is 1, `refRatio` takes the ratio field one `clk` cycle later.
- R5: On a cycle where `serLatch` is high and the control bit is 0, `fbRatio` takes the ratio field one `clk` cycle later.
- R6: The latch that is not selected keeps its value during a transfer. While `serLatch` is low, both latches keep their values.
- R7: `fbDisable` is 1 exactly when `fbRatio` was zero on the previous cycle, so it follows the latch with one cycle of delay.
- R8: `refDisable` is 1 exactly when `refRatio` was zero on the previous cycle, so it follows the latch with one cycle of delay.
- R9: While `serLatch` stays high, the latch is transparent. On every cycle the selected latch takes the current ratio field, including while bits are still being shifted in.
- R10: If more than 17 bits are shifted in before a transfer, only the last 17 bits count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| serClk | input | 1 | Serial bit clock; a bit is taken in on each of its rising edges |
| serData | input | 1 | Serial data line |
| serLatch | input | 1 | Latch strobe; while high, the selected latch loads |
| refRatio | output | 16 | Reference divider ratio latch |
| fbRatio | output | 16 | Feedback divider ratio latch |
| refDisable | output | 1 | High when the reference latch holds zero |
| fbDisable | output | 1 | High when the feedback latch holds zero |

## Verification
A rising edge of `serClk` updates the shift register on the same `clk` edge at which it is first seen. A cycle with `serLatch` high changes the selected latch at the next edge. A disable flag follows its latch one edge after that, so a flag changes two edges after the strobe. The bench drives inputs on falling edges and steps a queue-based model on each rising edge. It compares every output on the following falling edge, so each check lands on the cycle in which the result is due. Directed checks after each transfer wait several cycles, which lets both the latch and its flag settle first.

// File: rtl/loader_pkg.sv
package loader_pkg;
  // strobes issued by the control module to the datapath each cycle
  typedef struct packed {
    logic shiftEn;
    logic loadRef;
    logic loadFb;
  } strobes_t;
endpackage

// File: rtl/loader_ctrl.sv
module loader_ctrl
  import loader_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     serClk,
  input  logic     serLatch,
  input  logic     selBit,
  output strobes_t strobes
);
  logic serClkPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) serClkPrev <= 1'b0;
    else       serClkPrev <= serClk;
  end

  always_comb begin
    strobes.shiftEn = serClk & ~serClkPrev;
    strobes.loadRef = serLatch & selBit;
    strobes.loadFb  = serLatch & ~selBit;
  end
endmodule

// File: rtl/loader_datapath.sv
module loader_datapath
  import loader_pkg::*;
#(
  parameter int RATIO_W = 16,
  localparam int WORD_W = RATIO_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           strobes,
  input  logic               serData,
  output logic [WORD_W-1:0]  shiftWord,
  output logic               selBit,
  output logic [RATIO_W-1:0] refRatio,
  output logic [RATIO_W-1:0] fbRatio,
  output logic               refDisable,
  output logic               fbDisable
);
  localparam int NPATH = 2;  // index 0 feedback, 1 reference (matches control bit)

  logic [RATIO_W-1:0] field;
  logic [RATIO_W-1:0] latchQ  [NPATH];
  logic               loadVec [NPATH];
  logic               zeroQ   [NPATH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                shiftWord <= '0;
    else if (strobes.shiftEn) shiftWord <= {shiftWord[WORD_W-2:0], serData};
  end

  assign field  = shiftWord[WORD_W-1:1];
  assign selBit = shiftWord[0];

  assign loadVec[0] = strobes.loadFb;
  assign loadVec[1] = strobes.loadRef;

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        latchQ[p] <= '0;
        zeroQ[p]  <= 1'b1;
      end else begin
        if (loadVec[p]) latchQ[p] <= field;
        zeroQ[p] <= (latchQ[p] == '0);
      end
    end
  end

  assign fbRatio    = latchQ[0];
  assign refRatio   = latchQ[1];
  assign fbDisable  = zeroQ[0];
  assign refDisable = zeroQ[1];
endmodule

// File: rtl/serial_ratio_loader.sv
module serial_ratio_loader
  import loader_pkg::*;
#(
  parameter int RATIO_W = 16,
  localparam int WORD_W = RATIO_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               serClk,
  input  logic               serData,
  input  logic               serLatch,
  output logic [RATIO_W-1:0] refRatio,
  output logic [RATIO_W-1:0] fbRatio,
  output logic               refDisable,
  output logic               fbDisable
);
  strobes_t          strobes;
  logic              selBit;
  logic [WORD_W-1:0] shiftWord;

  loader_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serLatch(serLatch),
    .selBit(selBit), .strobes(strobes)
  );

  loader_datapath #(.RATIO_W(RATIO_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .serData(serData),
    .shiftWord(shiftWord), .selBit(selBit),
    .refRatio(refRatio), .fbRatio(fbRatio),
    .refDisable(refDisable), .fbDisable(fbDisable)
  );
endmodule

// File: rtl/loader_checker.sv
module loader_checker #(
  parameter int RATIO_W = 16,
  localparam int WORD_W = RATIO_W + 1
) (
  input logic               clk,
  input logic               rstN,
  input logic               serData,
  input logic               serLatch,
  input logic               shiftEn,
  input logic [WORD_W-1:0]  shiftWord,
  input logic [RATIO_W-1:0] refRatio,
  input logic [RATIO_W-1:0] fbRatio,
  input logic               refDisable,
  input logic               fbDisable
);
  assert_shift_in_R2: assert property (@(posedge clk) disable iff (!rstN)
    shiftEn |=> shiftWord == {$past(shiftWord[WORD_W-2:0]), $past(serData)});

  assert_no_shift_R2: assert property (@(posedge clk) disable iff (!rstN)
    !shiftEn |=> $stable(shiftWord));

  assert_ref_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    (serLatch && shiftWord[0]) |=> refRatio == $past(shiftWord[WORD_W-1:1]));

  assert_fb_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    (serLatch && !shiftWord[0]) |=> fbRatio == $past(shiftWord[WORD_W-1:1]));

  assert_fb_keep_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!serLatch || shiftWord[0]) |=> $stable(fbRatio));

  assert_ref_keep_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!serLatch || !shiftWord[0]) |=> $stable(refRatio));

  assert_fb_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> fbDisable == ($past(fbRatio) == '0));

  assert_ref_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> refDisable == ($past(refRatio) == '0));
endmodule

bind serial_ratio_loader loader_checker #(.RATIO_W(RATIO_W)) u_chk (
  .clk(clk), .rstN(rstN), .serData(serData), .serLatch(serLatch),
  .shiftEn(strobes.shiftEn), .shiftWord(shiftWord),
  .refRatio(refRatio), .fbRatio(fbRatio),
  .refDisable(refDisable), .fbDisable(fbDisable)
);

// File: tb/sim_serial_ratio_loader.sv
`timescale 1ns/1ps
module sim_serial_ratio_loader;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0, serData = 1'b0, serLatch = 1'b0;
  logic [15:0] refRatio, fbRatio;
  logic refDisable, fbDisable;

  always #2 clk = ~clk;  // 250 MHz

  serial_ratio_loader u0 (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .serLatch(serLatch), .refRatio(refRatio), .fbRatio(fbRatio),
    .refDisable(refDisable), .fbDisable(fbDisable)
  );

  int testsRun = 0;
  int testsFailed = 0;

  task automatic check(input string tag, input int actual, input int expected);
    testsRun++;
    if (actual !== expected) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
    end
  endtask

  // behavioural reference model, stepped on every rising edge
  bit q[$];
  int mRef, mFb, mRefDis, mFbDis, mPrevClk;

  task automatic modelReset();
    q.delete();
    for (int i = 0; i < 17; i++) q.push_back(1'b0);
    mRef = 0; mFb = 0; mRefDis = 1; mFbDis = 1; mPrevClk = 0;
  endtask

  initial modelReset();

  always @(posedge clk) begin
    if (!rstN) modelReset();
    else begin
      int fieldVal;
      bit ctl;
      fieldVal = 0;
      for (int i = 0; i < 16; i++) fieldVal = (fieldVal << 1) | int'(q[i]);
      ctl = q[16];
      mFbDis  = (mFb == 0);
      mRefDis = (mRef == 0);
      if (serLatch && ctl)  mRef = fieldVal;
      if (serLatch && !ctl) mFb  = fieldVal;
      if (serClk && mPrevClk == 0) begin
        q.push_back(serData);
        void'(q.pop_front());
      end
      mPrevClk = int'(serClk);
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      check("R4 R6 R9 model refRatio", int'(refRatio), mRef);
      check("R5 R6 R9 model fbRatio", int'(fbRatio), mFb);
      check("R8 model refDisable", int'(refDisable), mRefDis);
      check("R7 model fbDisable", int'(fbDisable), mFbDis);
    end
  end

  task automatic serBit(input bit b);
    @(negedge clk); serData = b; serClk = 1'b1;
    @(negedge clk); serData = ~b;   // toggled while high: must be ignored (R2)
    @(negedge clk);
    @(negedge clk); serClk = 1'b0;
    @(negedge clk);
  endtask

  task automatic shiftWordIn(input logic [15:0] ratio, input bit ctl);
    for (int i = 15; i >= 0; i--) serBit(ratio[i]);
    serBit(ctl);
  endtask

  task automatic strobe();
    @(negedge clk); serLatch = 1'b1;
    @(negedge clk); serLatch = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset refRatio", int'(refRatio), 0);
    check("R1 reset fbRatio", int'(fbRatio), 0);
    check("R1 reset refDisable", int'(refDisable), 1);
    check("R1 reset fbDisable", int'(fbDisable), 1);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after reset refDisable", int'(refDisable), 1);

    shiftWordIn(16'h1234, 1'b1); strobe();
    check("R3 R4 ref load", int'(refRatio), 16'h1234);
    check("R6 fb untouched", int'(fbRatio), 0);
    check("R8 refDisable low", int'(refDisable), 0);

    shiftWordIn(16'hBEEF, 1'b0); strobe();
    check("R2 R5 fb load", int'(fbRatio), 16'hBEEF);
    check("R6 ref untouched", int'(refRatio), 16'h1234);
    check("R7 fbDisable low", int'(fbDisable), 0);

    shiftWordIn(16'h8001, 1'b1);
    repeat (4) @(negedge clk);
    check("R6 no strobe ref kept", int'(refRatio), 16'h1234);

    for (int i = 0; i < 5; i++) serBit(1'b1);
    shiftWordIn(16'h0A5C, 1'b1); strobe();
    check("R10 extra bits dropped", int'(refRatio), 16'h0A5C);

    shiftWordIn(16'h0000, 1'b0);
    @(negedge clk); serLatch = 1'b1;
    @(negedge clk); serLatch = 1'b0;
    check("R5 fb zero loaded", int'(fbRatio), 0);
    check("R7 flag one cycle late", int'(fbDisable), 0);
    @(negedge clk);
    check("R7 fbDisable high", int'(fbDisable), 1);

    shiftWordIn(16'h0000, 1'b1); strobe();
    check("R8 refDisable high", int'(refDisable), 1);

    @(negedge clk); serLatch = 1'b1;
    shiftWordIn(16'h00F0, 1'b1);
    repeat (2) @(negedge clk);
    check("R9 transparent ref", int'(refRatio), 16'h00F0);
    serLatch = 1'b0;
    repeat (3) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule